// File: doc/BRIEF.md
# Read Strobe Eye-Training Controller

This block places the sampling point of the delayed read strobe inside the read data eye. Strobe and data arrive at the same moment, so a delay-lock loop supplies a base tap code that shifts the strobe by about a quarter of a clock period. After reset, or when asked to, the block walks a signed tap offset across its whole range on top of that base code. It asks the read datapath for one test read at each offset and collects a pass/fail verdict. It then keeps the widest unbroken run of passing offsets and stores the midpoint of that run.

The stored result is an offset and never an absolute code. The delay code sent to the delay line is rebuilt every cycle from the live base code plus that offset, and is clamped to the legal tap range. Later base-code updates for voltage and temperature drift therefore carry on through the trained point. While a sweep runs, `busy` is high, so functional reads are held off. If nothing passes, the block still finishes, flags the error and falls back to a zero offset.

Two valid/ready channels connect the block to the datapath. On the request channel the block raises `test_valid` and keeps it high until `test_ready` is seen with it. On the result channel the block offers `res_ready` and takes `res_pass` on the cycle where `res_valid` and `res_ready` are both high. The datapath may apply back-pressure on either channel by delaying its signal for any number of cycles. The block never drops a request and never takes a verdict it did not ask for.

Top module: `strobe_eye_trainer`

## Requirements
- R1: After reset release, `busy` is 1 and `done` is 0. The sweep tests offsets in rising order from the most negative value (-32 with default parameters) to the most positive (+31), one test per offset, so there are 64 tests per sweep.
- R2: After `dqs_code` changes for a new offset, `test_valid` does not rise until at least `settle_cycles` clock cycles later.
- R3: Once `test_valid` is high, it stays high until a cycle in which `test_ready` is also high. A verdict is taken only when `res_valid` and `res_ready` are both high. `test_valid` and `res_ready` are never high in the same cycle.
- R4: The trained offset comes from the longest run of consecutive passing offsets. When two runs are equally long, the earlier (more negative) run wins. The result is (left + right) shifted right arithmetically by one, so [-5,+9] gives 2 and [-9,-2] gives -6.
- R5: A passing run that starts at the lowest offset or ends at the highest offset is a valid window. Its sweep limit serves as its edge, so [-32,-30] gives -31 and [+28,+31] gives +29.
- R6: If no offset passes, `train_err` is set, `trained_ofs` is 0 and `done` still goes to 1. `train_err` stays set until the next retrain.
- R7: Once training is done, from the second clock edge after a change of `dll_code`, `dqs_code` equals the new `dll_code` plus `trained_ofs`.
- R8: The sum is clamped to the range 0 to 2^TAP_W-1 (0 to 127 by default). It never wraps.
- R9: A one-cycle `retrain` pulse, at any time, gives `busy` high with `done` and `train_err` low on the next cycle. It restarts the sweep from the lowest offset, and this holds even when the pulse arrives in the middle of a sweep.
- R10: While `done` is high, neither `test_valid` nor `res_ready` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the sweep starts when it is released |
| retrain | input | 1 | Pulse that restarts calibration |
| dll_code | input | TAP_W | Live base tap code from the delay-lock loop |
| settle_cycles | input | SETTLE_W | Number of wait cycles after each code change |
| test_valid | output | 1 | Request for a test read at the present code |
| test_ready | input | 1 | Datapath accepts the request |
| res_valid | input | 1 | Datapath presents a verdict |
| res_pass | input | 1 | Verdict: 1 means the data compared correctly |
| res_ready | output | 1 | Block is waiting for a verdict |
| dqs_code | output | TAP_W | Delay code sent to the strobe delay line |
| trained_ofs | output | OFS_W | Stored signed offset (two's complement) |
| busy | output | 1 | Training in progress; functional reads blocked |
| done | output | 1 | Training finished |
| train_err | output | 1 | The last sweep found no passing offset |

## Verification
The assertions assume that `retrain` is a single-cycle pulse. They also assume that the datapath answers each accepted request with exactly one verdict, offered only while `res_ready` is high. The request-hold property assumes that no retrain happens during the held cycle. The bench's responder keeps to these rules: it raises `test_ready` and `res_valid` for one cycle each after a short random delay, it answers only the request it has just accepted, and it issues a mid-sweep retrain only while the block sits in a settle wait with no exchange open. `dll_code` is held constant during each sweep, so the bench can recover each tested offset from `dqs_code`.

// File: rtl/eye_train_pkg.sv
package eye_train_pkg;
  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_REQ    = 3'd1,
    ST_RESP   = 3'd2,
    ST_FINISH = 3'd3,
    ST_DONE   = 3'd4
  } train_state_e;
endpackage

// File: rtl/eye_sweep_ctl.sv
module eye_sweep_ctl
  import eye_train_pkg::*;
#(
  parameter int OFS_W    = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       retrain,
  input  logic [SETTLE_W-1:0]        settle_cycles,
  input  logic                       test_ready,
  input  logic                       res_valid,
  output logic                       test_valid,
  output logic                       res_ready,
  output logic signed [OFS_W-1:0]    sweep_ofs,
  output logic                       sample_en,
  output logic                       finish,
  output logic                       busy,
  output logic                       done
);
  localparam logic signed [OFS_W-1:0] OFS_MIN = {1'b1, {(OFS_W-1){1'b0}}};
  localparam logic signed [OFS_W-1:0] OFS_MAX = {1'b0, {(OFS_W-1){1'b1}}};

  train_state_e        state;
  logic [SETTLE_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_SETTLE;
      sweep_ofs <= OFS_MIN;
      wait_cnt  <= '0;
    end else if (retrain) begin
      state     <= ST_SETTLE;
      sweep_ofs <= OFS_MIN;
      wait_cnt  <= '0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (wait_cnt == settle_cycles) state <= ST_REQ;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        ST_REQ: begin
          if (test_ready) state <= ST_RESP;
        end
        ST_RESP: begin
          if (res_valid) begin
            if (sweep_ofs == OFS_MAX) begin
              state <= ST_FINISH;
            end else begin
              sweep_ofs <= sweep_ofs + 1'b1;
              wait_cnt  <= '0;
              state     <= ST_SETTLE;
            end
          end
        end
        ST_FINISH: state <= ST_DONE;
        default:   state <= ST_DONE;
      endcase
    end
  end

  assign test_valid = (state == ST_REQ);
  assign res_ready  = (state == ST_RESP);
  assign sample_en  = (state == ST_RESP) && res_valid && !retrain;
  assign finish     = (state == ST_FINISH) && !retrain;
  assign done       = (state == ST_DONE);
  assign busy       = !done;
endmodule

// File: rtl/eye_window_track.sv
module eye_window_track #(
  parameter int OFS_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    sample_en,
  input  logic                    pass,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic                    finish,
  output logic signed [OFS_W-1:0] trained_ofs,
  output logic                    err
);
  localparam int LEN_W = OFS_W + 1;

  logic                    in_run;
  logic signed [OFS_W-1:0] cur_left;
  logic [LEN_W-1:0]        cur_len;
  logic signed [OFS_W-1:0] best_left, best_right;
  logic [LEN_W-1:0]        best_len;

  logic [LEN_W-1:0]        run_len_n;
  logic signed [OFS_W-1:0] run_left_n;
  logic signed [OFS_W:0]   edge_sum;
  logic signed [OFS_W-1:0] centre;

  always_comb begin
    run_len_n  = in_run ? cur_len + 1'b1 : LEN_W'(1);
    run_left_n = in_run ? cur_left : ofs;
    edge_sum   = {best_left[OFS_W-1], best_left} + {best_right[OFS_W-1], best_right};
    centre     = edge_sum[OFS_W:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_run      <= 1'b0;
      cur_left    <= '0;
      cur_len     <= '0;
      best_left   <= '0;
      best_right  <= '0;
      best_len    <= '0;
      trained_ofs <= '0;
      err         <= 1'b0;
    end else if (clear) begin
      in_run   <= 1'b0;
      cur_len  <= '0;
      best_len <= '0;
      err      <= 1'b0;
    end else begin
      if (sample_en) begin
        if (pass) begin
          in_run   <= 1'b1;
          cur_left <= run_left_n;
          cur_len  <= run_len_n;
          if (run_len_n > best_len) begin
            best_left  <= run_left_n;
            best_right <= ofs;
            best_len   <= run_len_n;
          end
        end else begin
          in_run <= 1'b0;
        end
      end
      if (finish) begin
        if (best_len == '0) begin
          err         <= 1'b1;
          trained_ofs <= '0;
        end else begin
          trained_ofs <= centre;
        end
      end
    end
  end
endmodule

// File: rtl/eye_code_sum.sv
module eye_code_sum #(
  parameter int TAP_W = 7,
  parameter int OFS_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAP_W-1:0]        base_code,
  input  logic signed [OFS_W-1:0] ofs,
  output logic [TAP_W-1:0]        code
);
  localparam int SW = ((TAP_W > OFS_W) ? TAP_W : OFS_W) + 2;
  localparam logic signed [SW-1:0] TAP_TOP = SW'((1 << TAP_W) - 1);

  logic signed [SW-1:0] base_s, ofs_s, sum_s;
  logic [TAP_W-1:0]     clamped;

  always_comb begin
    base_s = $signed({{(SW-TAP_W){1'b0}}, base_code});
    ofs_s  = $signed({{(SW-OFS_W){ofs[OFS_W-1]}}, ofs});
    sum_s  = base_s + ofs_s;
    if (sum_s < 0)             clamped = '0;
    else if (sum_s > TAP_TOP)  clamped = '1;
    else                       clamped = sum_s[TAP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code <= '0;
    else        code <= clamped;
  end
endmodule

// File: rtl/strobe_eye_trainer.sv
module strobe_eye_trainer #(
  parameter int TAP_W    = 7,
  parameter int OFS_W    = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    retrain,
  input  logic [TAP_W-1:0]        dll_code,
  input  logic [SETTLE_W-1:0]     settle_cycles,
  output logic                    test_valid,
  input  logic                    test_ready,
  input  logic                    res_valid,
  input  logic                    res_pass,
  output logic                    res_ready,
  output logic [TAP_W-1:0]        dqs_code,
  output logic signed [OFS_W-1:0] trained_ofs,
  output logic                    busy,
  output logic                    done,
  output logic                    train_err
);
  logic signed [OFS_W-1:0] sweep_ofs;
  logic signed [OFS_W-1:0] live_ofs;
  logic                    sample_en;
  logic                    finish;

  eye_sweep_ctl #(.OFS_W(OFS_W), .SETTLE_W(SETTLE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .retrain(retrain), .settle_cycles(settle_cycles),
    .test_ready(test_ready), .res_valid(res_valid),
    .test_valid(test_valid), .res_ready(res_ready), .sweep_ofs(sweep_ofs),
    .sample_en(sample_en), .finish(finish), .busy(busy), .done(done)
  );

  eye_window_track #(.OFS_W(OFS_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(retrain), .sample_en(sample_en),
    .pass(res_pass), .ofs(sweep_ofs), .finish(finish),
    .trained_ofs(trained_ofs), .err(train_err)
  );

  assign live_ofs = busy ? sweep_ofs : trained_ofs;

  eye_code_sum #(.TAP_W(TAP_W), .OFS_W(OFS_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .base_code(dll_code), .ofs(live_ofs), .code(dqs_code)
  );
endmodule

// File: rtl/strobe_eye_trainer_chk.sv
module strobe_eye_trainer_chk #(
  parameter int OFS_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    retrain,
  input logic                    test_valid,
  input logic                    test_ready,
  input logic                    res_ready,
  input logic signed [OFS_W-1:0] trained_ofs,
  input logic                    busy,
  input logic                    done,
  input logic                    train_err
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_valid && !test_ready && !retrain) |=> test_valid);

  p_chan_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_valid && res_ready));

  p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!test_valid && !res_ready));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    train_err |-> (done && trained_ofs == '0));

  p_retrain_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (busy && !done && !train_err));
endmodule

bind strobe_eye_trainer strobe_eye_trainer_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retrain(retrain), .test_valid(test_valid),
  .test_ready(test_ready), .res_ready(res_ready), .trained_ofs(trained_ofs),
  .busy(busy), .done(done), .train_err(train_err)
);

// File: tb/strobe_eye_trainer_bench.sv
`timescale 1ns/1ps
module strobe_eye_trainer_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              retrain = 1'b0;
  logic [6:0]        dll_code = 7'd64;
  logic [3:0]        settle_cycles = 4'd3;
  logic              test_valid, test_ready = 1'b0;
  logic              res_valid = 1'b0, res_pass = 1'b0, res_ready;
  logic [6:0]        dqs_code;
  logic signed [5:0] trained_ofs;
  logic              busy, done, train_err;

  always #4 clk = ~clk;

  strobe_eye_trainer u_strobe_eye_trainer (
    .clk(clk), .rst_n(rst_n), .retrain(retrain), .dll_code(dll_code),
    .settle_cycles(settle_cycles), .test_valid(test_valid), .test_ready(test_ready),
    .res_valid(res_valid), .res_pass(res_pass), .res_ready(res_ready),
    .dqs_code(dqs_code), .trained_ofs(trained_ofs), .busy(busy), .done(done),
    .train_err(train_err)
  );

  int n_checks = 0, n_fail = 0;
  int win_lo[2], win_hi[2], n_win = 0;
  int exp_next = -32, seq_err = 0, n_tests = 0;
  int cyc = 0, last_chg = 0, min_gap = 1000;
  logic [6:0] prev_code = '0;
  logic prev_tv = 1'b0;
  logic resp_busy = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic passes(input int o);
    for (int i = 0; i < n_win; i++)
      if (o >= win_lo[i] && o <= win_hi[i]) return 1'b1;
    return 1'b0;
  endfunction

  // settle-gap monitor (R2)
  always @(negedge clk) begin
    cyc++;
    if (dqs_code != prev_code) last_chg = cyc;
    if (test_valid && !prev_tv && (cyc - last_chg) < min_gap) min_gap = cyc - last_chg;
    prev_code = dqs_code;
    prev_tv   = test_valid;
  end

  // datapath responder
  initial begin
    forever begin
      @(negedge clk);
      if (test_valid) begin
        int o;
        resp_busy = 1'b1;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        o = int'(dqs_code) - int'(dll_code);
        if (o != exp_next) seq_err++;
        exp_next = o + 1;
        n_tests++;
        test_ready = 1'b1;
        @(negedge clk);
        test_ready = 1'b0;
        while (!res_ready) @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        res_valid = 1'b1;
        res_pass  = passes(o);
        @(negedge clk);
        res_valid = 1'b0;
        res_pass  = 1'b0;
        resp_busy = 1'b0;
      end
    end
  end

  task automatic wait_done();
    int k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic start_sweep(input int settle);
    settle_cycles = 4'(settle);
    min_gap = 1000; seq_err = 0; n_tests = 0; exp_next = -32;
    @(negedge clk);
    retrain = 1'b1;
    @(negedge clk);
    retrain = 1'b0;
  endtask

  task automatic finish_checks(input string req, input int exp_ofs);
    wait_done();
    repeat (2) @(negedge clk);
    chk(done === 1'b1, "R1 done", done, 1);
    chk(seq_err == 0 && n_tests == 64, "R1 sweep order", n_tests, 64);
    chk(int'(trained_ofs) == exp_ofs, req, int'(trained_ofs), exp_ofs);
    chk(int'(dqs_code) == int'(dll_code) + exp_ofs, "R7 code", dqs_code, int'(dll_code) + exp_ofs);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R1 reset busy", busy, 1);
    chk(test_valid === 1'b0, "R1 reset no request", test_valid, 0);
  endtask

  task automatic t_single();
    n_win = 1; win_lo[0] = -5; win_hi[0] = 9;
    start_sweep(5);
    finish_checks("R4 single window", 2);
    chk(min_gap >= 5, "R2 settle gap", min_gap, 5);
    chk(train_err === 1'b0, "R6 no error", train_err, 0);
  endtask

  task automatic t_two();
    n_win = 2; win_lo[0] = -20; win_hi[0] = -17; win_lo[1] = 3; win_hi[1] = 12;
    start_sweep(2);
    finish_checks("R4 widest run", 7);
    n_win = 2; win_lo[0] = -20; win_hi[0] = -11; win_lo[1] = 5; win_hi[1] = 14;
    start_sweep(0);
    finish_checks("R4 tie earliest", -16);
    chk(min_gap >= 0, "R2 zero settle", min_gap, 0);
  endtask

  task automatic t_negodd();
    n_win = 1; win_lo[0] = -9; win_hi[0] = -2;
    start_sweep(1);
    finish_checks("R4 arithmetic shift", -6);
  endtask

  task automatic t_edges();
    n_win = 1; win_lo[0] = -32; win_hi[0] = -30;
    start_sweep(1);
    finish_checks("R5 low limit", -31);
    n_win = 1; win_lo[0] = 28; win_hi[0] = 31;
    start_sweep(1);
    finish_checks("R5 high limit", 29);
  endtask

  task automatic t_nopass();
    n_win = 0;
    start_sweep(1);
    finish_checks("R6 zero offset", 0);
    chk(train_err === 1'b1, "R6 error flag", train_err, 1);
    repeat (10) @(negedge clk);
    chk(train_err === 1'b1, "R6 sticky", train_err, 1);
  endtask

  task automatic t_track_sat();
    n_win = 1; win_lo[0] = -5; win_hi[0] = 9;
    start_sweep(1);
    finish_checks("R4 retrain result", 2);
    dll_code = 7'd80;
    repeat (2) @(negedge clk);
    chk(dqs_code == 7'd82, "R7 tracks base", dqs_code, 82);
    dll_code = 7'd64;
    n_win = 1; win_lo[0] = 28; win_hi[0] = 31;
    start_sweep(1);
    wait_done();
    dll_code = 7'd120;
    repeat (2) @(negedge clk);
    chk(dqs_code == 7'd127, "R8 clamp high", dqs_code, 127);
    dll_code = 7'd64;
    n_win = 1; win_lo[0] = -32; win_hi[0] = -30;
    start_sweep(1);
    wait_done();
    dll_code = 7'd10;
    repeat (2) @(negedge clk);
    chk(dqs_code == 7'd0, "R8 clamp low", dqs_code, 0);
    dll_code = 7'd64;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_retrain_mid();
    int k = 0;
    n_win = 1; win_lo[0] = -5; win_hi[0] = 9;
    start_sweep(2);
    chk(busy === 1'b1 && done === 1'b0 && train_err === 1'b0, "R9 busy after retrain", busy, 1);
    while (!(n_tests >= 10 && !resp_busy && !test_valid && !res_ready) && k < 5000) begin
      @(negedge clk); k++;
    end
    min_gap = 1000; seq_err = 0; n_tests = 0; exp_next = -32;
    retrain = 1'b1;
    @(negedge clk);
    retrain = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R9 mid-sweep restart", done, 0);
    finish_checks("R9 restart result", 2);
  endtask

  task automatic t_quiet();
    int seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (test_valid || res_ready) seen++;
    end
    chk(seen == 0, "R10 quiet when done", seen, 0);
    chk(done === 1'b1 && busy === 1'b0, "R10 done holds", done, 1);
  endtask

  task automatic t_handshake();
    int bad = 0;
    n_win = 1; win_lo[0] = 0; win_hi[0] = 3;
    start_sweep(0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (test_valid && res_ready) bad++;
    end
    chk(bad == 0, "R3 channels exclusive", bad, 0);
    finish_checks("R3 result through handshake", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_win = 1; win_lo[0] = -5; win_hi[0] = 9;
    settle_cycles = 4'd3;
    t_reset();
    finish_checks("R4 power-up training", 2);
    chk(min_gap >= 3, "R2 power-up settle", min_gap, 3);
    t_single();
    t_two();
    t_negodd();
    t_edges();
    t_nopass();
    t_track_sat();
    t_retrain_mid();
    t_quiet();
    t_handshake();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule